// File: doc/BRIEF.md
# Sampling-Phase Tuning Search Engine

This engine picks the delay-line setting for a high-speed memory-card interface by trial. It drives a 5-bit phase code to an external delay line. The low four bits select one of 16 taps, and the top bit selects the opposite clock edge. For every code it tried, it asks an external responder for one tuning exchange. The exchange uses a start pulse, followed later by a done pulse that carries a pass bit.

For each clock edge, the engine finds the first passing tap and the run of passing taps that follows it. It keeps the widest run seen across both edges and programs the centre of that run. The receive field is tuned first and committed. The transmit field is then tuned the same way, with the committed receive value held fixed. A final exchange gives the overall status. The result is presented as a 32-bit phase register image.

Top module: `ptune_engine`

## Requirements
- R1: After reset, phase_o is all zero, and busy_o, done_o and xchg_start_o are low.
- R2: Each trial raises xchg_start_o for exactly one cycle while busy_o is high. At most one exchange is outstanding, and phase_o does not change between a start pulse and its done pulse.
- R3: In phase_o, the receive field is at bits 20:16 and the transmit field is at bits 7:3. In each field, the top bit is the invert flag and the low four bits are the tap. Bits 2:0 are enables, set from the first trial onward. Every other bit is zero.
- R4: Per edge, taps are tried upward from 0 until one passes; this is the left boundary. If none passes, the left boundary is 16 and the edge gives no window. The right search then tries upward from left+1 and stops at the first failing tap, or at 16 after tap 15 passes.
- R5: The window width is right minus left. The centre tap is ((right-1)+left)/2, rounded down, with the edge's invert flag in bit 4.
- R6: The non-inverted edge is swept before the inverted edge. A window replaces the stored best only if it is strictly wider, so a tie keeps the non-inverted result.
- R7: The receive sweep runs first. During it, the transmit field holds out_init_i. The chosen receive code is committed before any transmit trial.
- R8: The transmit sweep starts from a cleared best window. The committed receive field stays unchanged throughout it.
- R9: A sweep with no passing tap on either edge commits code 0 (tap 0, non-inverted).
- R10: After both sweeps, exactly one further exchange is run. Its pass bit appears on status_o when done_o pulses for one cycle, and busy_o is low from that cycle on.
- R11: start_i is ignored while busy_o is high. The run in progress is not restarted and its result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a tuning run (only acted on while idle) |
| out_init_i | input | 5 | Transmit code held during the receive sweep |
| xchg_start_o | output | 1 | One-cycle request for a tuning exchange |
| xchg_done_i | input | 1 | Exchange finished |
| xchg_pass_i | input | 1 | Exchange result, valid with xchg_done_i |
| phase_o | output | 32 | Phase register image driven to the delay line |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| status_o | output | 1 | Pass bit of the final exchange |

## Verification
A wrong boundary register or a wrong tap counter changes the number of exchanges issued. It therefore shows up in the trial count and in the committed field as soon as a sweep ends. A best-window tracker that is not cleared, or that keeps ties the wrong way, leaves a stale or inverted code in bits 7:3 or 20:16, which is visible when done_o pulses. A handshake fault shows within one exchange, as a second start pulse, or as a phase change while an exchange is still outstanding. A responder model indexed by field, edge and tap produces windows at the range ends, ties, several runs, and sweeps with no passing tap at all.

// File: rtl/ptune_pkg.sv
package ptune_pkg;
  parameter int unsigned TAP_W = 4;
  localparam int unsigned NTAP    = 1 << TAP_W;
  localparam int unsigned FLD_W   = TAP_W + 1;
  localparam int unsigned WID_W   = TAP_W + 1;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned IN_LSB  = 16;
  localparam int unsigned OUT_LSB = 3;
  localparam int unsigned EN_W    = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_COMMIT} st_e;
  typedef enum logic [1:0] {PH_IN, PH_OUT, PH_CHK} ph_e;
endpackage

// File: rtl/ptune_xchg.sv
module ptune_xchg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic done_i,
  input  logic pass_i,
  output logic start_o,
  output logic ack_o,
  output logic pass_o
);
  logic start_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      start_q <= issue_i && !pend_q;
      if (pend_q && done_i) pend_q <= 1'b0;
      else if (issue_i)     pend_q <= 1'b1;
    end
  end

  // done without an outstanding request is dropped
  assign ack_o   = pend_q && done_i;
  assign pass_o  = pass_i;
  assign start_o = start_q;
endmodule

// File: rtl/ptune_win_calc.sv
module ptune_win_calc
  import ptune_pkg::*;
(
  input  logic [WID_W-1:0] left_i,
  input  logic [WID_W-1:0] right_i,
  input  logic             edge_i,
  output logic [WID_W-1:0] width_o,
  output logic [FLD_W-1:0] centre_o
);
  logic [WID_W:0] sum;

  always_comb begin
    width_o  = right_i - left_i;
    sum      = {1'b0, right_i} + {1'b0, left_i} - (WID_W+1)'(1);
    centre_o = {edge_i, sum[TAP_W:1]};
  end
endmodule

// File: rtl/ptune_best_track.sv
module ptune_best_track
  import ptune_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [WID_W-1:0] width_i,
  input  logic [FLD_W-1:0] centre_i,
  output logic [FLD_W-1:0] best_centre_o
);
  logic [WID_W-1:0] best_w_q;
  logic [FLD_W-1:0] best_c_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_w_q <= '0;
      best_c_q <= '0;
    end else if (clr_i) begin
      best_w_q <= '0;
      best_c_q <= '0;
    end else if (upd_i && (width_i > best_w_q)) begin
      best_w_q <= width_i;
      best_c_q <= centre_i;
    end
  end

  assign best_centre_o = best_c_q;
endmodule

// File: rtl/ptune_engine.sv
module ptune_engine
  import ptune_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [FLD_W-1:0] out_init_i,
  output logic             xchg_start_o,
  input  logic             xchg_done_i,
  input  logic             xchg_pass_i,
  output logic [REG_W-1:0] phase_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             status_o
);
  st_e              st_q;
  ph_e              ph_q;
  logic             edge_q, rsrch_q, en_q, done_q, status_q;
  logic [TAP_W-1:0] tap_q;
  logic [WID_W-1:0] left_q;
  logic [FLD_W-1:0] in_q, out_q;

  logic             issue, ack, pass;
  logic             tap_last, sweep_act;
  logic [WID_W-1:0] tap_ext, left_now, fin_right, win_w;
  logic             fin, fin_hit, trk_clr;
  logic [FLD_W-1:0] trial, win_c, best_c, in_fld, out_fld;

  ptune_xchg u_xchg (
    .clk_i, .rst_ni,
    .issue_i (issue),
    .done_i  (xchg_done_i),
    .pass_i  (xchg_pass_i),
    .start_o (xchg_start_o),
    .ack_o   (ack),
    .pass_o  (pass)
  );

  assign issue     = (st_q == ST_ISSUE);
  assign trial     = {edge_q, tap_q};
  assign tap_last  = (tap_q == '1);
  assign tap_ext   = {1'b0, tap_q};
  assign left_now  = rsrch_q ? left_q : tap_ext;
  assign sweep_act = (st_q == ST_ISSUE) || (st_q == ST_WAIT);

  // edge termination on the current acknowledge
  always_comb begin
    fin       = 1'b0;
    fin_hit   = 1'b0;
    fin_right = '0;
    if (st_q == ST_WAIT && ack && ph_q != PH_CHK) begin
      if (!rsrch_q) begin
        if (tap_last) begin
          fin       = 1'b1;
          fin_hit   = pass;
          fin_right = WID_W'(NTAP);
        end
      end else if (!pass) begin
        fin       = 1'b1;
        fin_hit   = 1'b1;
        fin_right = tap_ext;
      end else if (tap_last) begin
        fin       = 1'b1;
        fin_hit   = 1'b1;
        fin_right = WID_W'(NTAP);
      end
    end
  end

  ptune_win_calc u_calc (
    .left_i   (left_now),
    .right_i  (fin_right),
    .edge_i   (edge_q),
    .width_o  (win_w),
    .centre_o (win_c)
  );

  assign trk_clr = (st_q == ST_IDLE && start_i) || (st_q == ST_COMMIT && ph_q == PH_IN);

  ptune_best_track u_track (
    .clk_i, .rst_ni,
    .clr_i         (trk_clr),
    .upd_i         (fin && fin_hit),
    .width_i       (win_w),
    .centre_i      (win_c),
    .best_centre_o (best_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ph_q     <= PH_IN;
      edge_q   <= 1'b0;
      rsrch_q  <= 1'b0;
      tap_q    <= '0;
      left_q   <= '0;
      in_q     <= '0;
      out_q    <= '0;
      en_q     <= 1'b0;
      done_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_ISSUE;
          ph_q    <= PH_IN;
          edge_q  <= 1'b0;
          rsrch_q <= 1'b0;
          tap_q   <= '0;
          in_q    <= '0;
          out_q   <= out_init_i;
          en_q    <= 1'b1;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (ack) begin
          if (ph_q == PH_CHK) begin
            status_q <= pass;
            done_q   <= 1'b1;
            st_q     <= ST_IDLE;
          end else if (fin) begin
            rsrch_q <= 1'b0;
            tap_q   <= '0;
            if (!edge_q) begin
              edge_q <= 1'b1;
              st_q   <= ST_ISSUE;
            end else begin
              st_q <= ST_COMMIT;
            end
          end else begin
            if (!rsrch_q && pass) begin
              left_q  <= tap_ext;
              rsrch_q <= 1'b1;
            end
            tap_q <= tap_q + 1'b1;
            st_q  <= ST_ISSUE;
          end
        end
        ST_COMMIT: begin
          if (ph_q == PH_IN) begin
            in_q <= best_c;
            ph_q <= PH_OUT;
          end else begin
            out_q <= best_c;
            ph_q  <= PH_CHK;
          end
          edge_q  <= 1'b0;
          rsrch_q <= 1'b0;
          tap_q   <= '0;
          st_q    <= ST_ISSUE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_fld  = (sweep_act && ph_q == PH_IN)  ? trial : in_q;
  assign out_fld = (sweep_act && ph_q == PH_OUT) ? trial : out_q;

  always_comb begin
    phase_o                    = '0;
    phase_o[EN_W-1:0]          = {EN_W{en_q}};
    phase_o[OUT_LSB +: FLD_W]  = out_fld;
    phase_o[IN_LSB +: FLD_W]   = in_fld;
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign status_o = status_q;
endmodule

// File: rtl/ptune_checker.sv
module ptune_checker
  import ptune_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             xchg_start_o,
  input logic             xchg_done_i,
  input logic [REG_W-1:0] phase_o,
  input logic             busy_o,
  input logic             done_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (xchg_start_o || pend_q) && !xchg_done_i;
  end

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_start_o |=> !xchg_start_o); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_start_o |-> !pend_q); // R2
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_start_o |-> busy_o); // R2
  AST_PHASE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((xchg_start_o || pend_q) && !xchg_done_i) |=> $stable(phase_o)); // R2
  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_start_o |-> (phase_o[EN_W-1:0] == {EN_W{1'b1}})); // R3
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(phase_o)); // R10
endmodule

bind ptune_engine ptune_checker i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .xchg_start_o (xchg_start_o),
  .xchg_done_i  (xchg_done_i),
  .phase_o      (phase_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/test_ptune_engine.sv
module test_ptune_engine;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct packed {
    logic [15:0] i0, i1, o0, o1;
    logic [4:0]  init_out;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{16'h0FF0, 16'h00F0, 16'h0003, 16'hFFFF, 5'h17, 2'd1},
    '{16'h00F0, 16'h0F00, 16'h8000, 16'h0000, 5'h0F, 2'd2},
    '{16'hC000, 16'hE000, 16'hFFFF, 16'hFFFF, 5'h00, 2'd3},
    '{16'h0F0F, 16'h0001, 16'h0001, 16'h0006, 5'h10, 2'd1},
    '{16'h0000, 16'h0000, 16'h00FF, 16'h0000, 5'h05, 2'd2},
    '{16'h0000, 16'h8000, 16'h0100, 16'h0000, 5'h08, 2'd1},
    '{16'h0001, 16'h0000, 16'hFFFE, 16'h7FFF, 5'h01, 2'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, done_r = 1'b0, pass_r = 1'b0;
  logic [4:0]  init_out = '0;
  logic        xstart, busy, done, status;
  logic [31:0] phase;

  logic [15:0] mi0, mi1, mo0, mo1;
  int cur_lat = 1, n_trial = 0, n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ptune_engine i_ptune_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .out_init_i(init_out),
    .xchg_start_o(xstart), .xchg_done_i(done_r), .xchg_pass_i(pass_r),
    .phase_o(phase), .busy_o(busy), .done_o(done), .status_o(status)
  );

  function automatic logic ok_f(input logic [15:0] m0, m1, input logic [4:0] f);
    return f[4] ? m1[f[3:0]] : m0[f[3:0]];
  endfunction

  function automatic logic oracle(input logic [31:0] p);
    return ok_f(mi0, mi1, p[20:16]) && ok_f(mo0, mo1, p[7:3]);
  endfunction

  // reference sweep over both edges
  function automatic void sweep(input logic [15:0] m0, m1, output logic [4:0] c, output int trials);
    int bw = 0;
    c = '0;
    trials = 0;
    for (int e = 0; e < 2; e++) begin
      logic [15:0] m = (e == 0) ? m0 : m1;
      int l = 16, r;
      for (int t = 0; t < 16; t++) if (m[t] && l == 16) l = t;
      if (l == 16) begin
        trials += 16;
      end else begin
        r = l + 1;
        while (r < 16 && m[r]) r++;
        trials += (l + 1) + ((r < 16) ? (r - l) : (15 - l));
        if (r - l > bw) begin
          bw = r - l;
          c = {e[0], 4'((r - 1 + l) / 2)};
        end
      end
    end
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // responder: one exchange per start pulse
  initial begin
    logic [31:0] cap;
    forever begin
      @(negedge clk);
      if (xstart === 1'b1) begin
        cap = phase;
        n_trial++;
        repeat (cur_lat - 1) @(negedge clk);
        pass_r = oracle(cap);
        done_r = 1'b1;
        @(negedge clk);
        done_r = 1'b0;
      end
    end
  end

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (done === 1'b1) begin ok = 1; break; end
    end
    if (!ok) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 actual=%h expected=%h", done, 1'b1);
    end
  endtask

  task automatic run_vec(input int v, input bit poke);
    logic [4:0] ci, co;
    int ti, to;
    logic st_exp;
    bit ok;
    mi0 = VEC[v].i0; mi1 = VEC[v].i1; mo0 = VEC[v].o0; mo1 = VEC[v].o1;
    cur_lat = int'(VEC[v].lat);
    init_out = VEC[v].init_out;
    if (ok_f(mo0, mo1, init_out)) sweep(mi0, mi1, ci, ti);
    else sweep(16'h0, 16'h0, ci, ti);
    if (ok_f(mi0, mi1, ci)) sweep(mo0, mo1, co, to);
    else sweep(16'h0, 16'h0, co, to);
    st_exp = ok_f(mi0, mi1, ci) && ok_f(mo0, mo1, co);
    n_trial = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 busy after start", 32'(busy), 32'd1);
    if (poke) begin
      repeat (25) @(negedge clk);
      init_out = 5'h03;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait_done(ok);
    if (ok) begin
      chk($sformatf("R3 R5 R6 R7 vec%0d rx field", v), 32'(phase[20:16]), 32'(ci));
      chk($sformatf("R8 vec%0d tx field", v), 32'(phase[7:3]), 32'(co));
      chk($sformatf("R3 vec%0d register", v), phase, {11'd0, ci, 8'd0, co, 3'b111});
      chk($sformatf("R4 vec%0d exchanges", v), 32'(n_trial), 32'(ti + to + 1));
      chk($sformatf("R10 vec%0d status", v), 32'(status), 32'(st_exp));
      if (poke) chk("R11 start during run ignored", 32'(n_trial), 32'(ti + to + 1));
      @(negedge clk);
      chk("R10 done one cycle", {busy, done}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset phase", phase, 32'd0);
    chk("R1 reset flags", {busy, done, xstart}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {busy, done, xstart}, 32'd0);
    for (int v = 0; v < NV; v++) run_vec(v, 1'b0);
    // R9: no receive window anywhere commits code 0 in both fields
    run_vec(4, 1'b0);
    chk("R9 empty sweep code", {phase[20:16], phase[7:3]}, 32'd0);
    run_vec(0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog global actual=%h expected=%h", busy, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule